// File: doc/BRIEF.md
# Indirect Register Access Controller

This block lets a host processor reach a bank of registers that are not mapped directly into its address space. The host first places a data word in a staging register, then writes a command word carrying a target address code and a direction flag. That command write is the only thing that launches an access. Codes in the lower half of the code space go to fast local registers that answer in a single cycle. Codes in the upper half go to a slow serial management engine, which answers with a done handshake after an arbitrary number of cycles.

While an access is in flight, the block drops any further command writes. Such a write does not change the command register and does not disturb the running access. The host learns that an access has finished in one of two ways. It can poll a ready register that holds one bit per access type, or it can wait for a sticky completion interrupt that is gated by a local enable and a global enable. On a read, the returned word is placed in the staging register. The command register answers at two host offsets, 0x028 and 0x068, so two software agents can share one physical register and one busy state.

Top module: `indirect_access_ctrl`

## Requirements
- R1: After reset, the ready register (offset 0x030) reads 0x3, and the command, staging (0x020), interrupt status (0x034), local enable (0x038) and global enable (0x03C) registers all read 0. The output irq is 0.
- R2: The command register holds the address code in bits 9:0 and the write flag in bit 15 (1 = write, 0 = read). Every other bit reads back as 0, whatever value was written to it.
- R3: A write command with a code below 0x200 asserts fast_req for exactly one cycle. In that cycle fast_we is 1, fast_addr is the code and fast_wdata is the staging value. The access then completes.
- R4: When a read completes, the target's returned data (fast_rdata or mgmt_rdata) is stored in the staging register.
- R5: A code at or above 0x200 asserts mgmt_req, together with mgmt_addr and mgmt_we. mgmt_req stays high until mgmt_done is sampled high, and then falls.
- R6: Ready bit 0 belongs to fast accesses and bit 1 to management accesses. The bit of the active type reads 0 for the whole access, and the other bit stays 1.
- R7: A command write made while an access is busy is dropped. The command readback is unchanged, no new target request appears, and the ready bits are unaffected.
- R8: The write data sent to the target is the staging value captured when the command is accepted. Later writes to the staging register do not change it.
- R9: Offsets 0x028 and 0x068 reach the same command register and the same busy state.
- R10: Each completion sets interrupt status bit 0. The bit stays set until the host clears it. irq is high only while status bit 0, local enable bit 0 and global enable bit 0 are all set.
- R11: Writing 1 to status bit 0 clears it. If a clear and a completion fall in the same cycle, the bit ends up set.
- R12: Writes to the registers other than the command register never start an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe, one cycle per write |
| hst_addr | input | 8 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Combinational readback for hst_addr |
| irq | output | 1 | Gated completion interrupt |
| fast_req | output | 1 | Fast-target access strobe |
| fast_we | output | 1 | Fast access is a write |
| fast_addr | output | 10 | Fast target address code |
| fast_wdata | output | 32 | Fast write data |
| fast_rdata | input | 32 | Fast target read data, valid while fast_req |
| mgmt_req | output | 1 | Management access request, held until done |
| mgmt_we | output | 1 | Management access is a write |
| mgmt_addr | output | 10 | Management address code |
| mgmt_wdata | output | 32 | Management write data |
| mgmt_rdata | input | 32 | Management read data, valid with mgmt_done |
| mgmt_done | input | 1 | Management access complete |

## Verification
Two functions can land on the same clock edge: a host write-1-to-clear of the completion status, and the completion of a management access that sets that status again. The bench raises mgmt_done and the clearing host write in the same cycle of a management read. After the edge it requires the status bit to read 1 and the staging register to hold the returned read data. A later clear with no completion pending must bring the bit back to 0.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int HOST_AW = 8;
  localparam int WE_BIT  = 15;

  localparam logic [HOST_AW-1:0] OFF_STAGE = 8'h20;
  localparam logic [HOST_AW-1:0] OFF_CMD_A = 8'h28;
  localparam logic [HOST_AW-1:0] OFF_CMD_B = 8'h68;
  localparam logic [HOST_AW-1:0] OFF_READY = 8'h30;
  localparam logic [HOST_AW-1:0] OFF_ISTS  = 8'h34;
  localparam logic [HOST_AW-1:0] OFF_IEN   = 8'h38;
  localparam logic [HOST_AW-1:0] OFF_GEN   = 8'h3C;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FAST = 2'd1,
    ST_MGMT = 2'd2
  } acc_state_e;
endpackage

// File: rtl/iac_host_regs.sv
module iac_host_regs
  import iac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_wr,
  input  logic [HOST_AW-1:0]  hst_addr,
  input  logic [DATA_W-1:0]   hst_wdata,
  output logic [DATA_W-1:0]   hst_rdata,
  output logic                cmd_wr,
  input  logic                accept,
  input  logic                done_evt,
  input  logic                rd_cap,
  input  logic [DATA_W-1:0]   rd_data,
  input  logic [1:0]          ready,
  output logic [DATA_W-1:0]   stage_q,
  output logic                irq
);
  logic [DATA_W-1:0] stage_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              we_q, we_d;
  logic              sts_q, sts_d;
  logic              ien_q, ien_d;
  logic              gen_q, gen_d;
  logic              stage_en, cmd_en, sts_en, ien_en, gen_en;
  logic              sts_clr;

  assign cmd_wr  = hst_wr && (hst_addr == OFF_CMD_A || hst_addr == OFF_CMD_B);
  assign sts_clr = hst_wr && (hst_addr == OFF_ISTS) && hst_wdata[0];

  always_comb begin
    stage_en = 1'b0;
    stage_d  = stage_q;
    if (hst_wr && hst_addr == OFF_STAGE) begin
      stage_en = 1'b1;
      stage_d  = hst_wdata;
    end
    if (rd_cap) begin
      stage_en = 1'b1;
      stage_d  = rd_data;
    end
    cmd_en = accept;
    code_d = hst_wdata[CODE_W-1:0];
    we_d   = hst_wdata[WE_BIT];
    sts_en = sts_clr || done_evt;
    sts_d  = done_evt;
    ien_en = hst_wr && hst_addr == OFF_IEN;
    ien_d  = hst_wdata[0];
    gen_en = hst_wr && hst_addr == OFF_GEN;
    gen_d  = hst_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      code_q  <= '0;
      we_q    <= 1'b0;
      sts_q   <= 1'b0;
      ien_q   <= 1'b0;
      gen_q   <= 1'b0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (cmd_en) begin
        code_q <= code_d;
        we_q   <= we_d;
      end
      if (sts_en) sts_q <= sts_d;
      if (ien_en) ien_q <= ien_d;
      if (gen_en) gen_q <= gen_d;
    end
  end

  assign irq = sts_q && ien_q && gen_q;

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      OFF_STAGE:           hst_rdata = stage_q;
      OFF_CMD_A, OFF_CMD_B: begin
        hst_rdata[CODE_W-1:0] = code_q;
        hst_rdata[WE_BIT]     = we_q;
      end
      OFF_READY:           hst_rdata[1:0] = ready;
      OFF_ISTS:            hst_rdata[0]   = sts_q;
      OFF_IEN:             hst_rdata[0]   = ien_q;
      OFF_GEN:             hst_rdata[0]   = gen_q;
      default:             hst_rdata = '0;
    endcase
  end

  // R7: a command write seen while the ready bits show activity leaves the command untouched
  a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ready != 2'b11) && cmd_wr |=> $stable(code_q) && $stable(we_q));
  // R11: a completion always leaves the status set, even under a clear
  a_r11_completion_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> sts_q);
  // R10: the status bit is sticky until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q && !sts_clr |=> sts_q);
endmodule

// File: rtl/iac_sequencer.sv
module iac_sequencer
  import iac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 10,
  parameter int SLOW_BASE = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CODE_W-1:0] new_code,
  input  logic              new_we,
  input  logic [DATA_W-1:0] stage_q,
  output logic              accept,
  output logic              done_evt,
  output logic              rd_cap,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        ready,
  output logic              fast_req,
  output logic              fast_we,
  output logic [CODE_W-1:0] fast_addr,
  output logic [DATA_W-1:0] fast_wdata,
  input  logic [DATA_W-1:0] fast_rdata,
  output logic              mgmt_req,
  output logic              mgmt_we,
  output logic [CODE_W-1:0] mgmt_addr,
  output logic [DATA_W-1:0] mgmt_wdata,
  input  logic [DATA_W-1:0] mgmt_rdata,
  input  logic              mgmt_done
);
  localparam logic [CODE_W-1:0] SLOW_CODE = CODE_W'(SLOW_BASE);

  acc_state_e        state_q, state_d;
  logic [CODE_W-1:0] code_q;
  logic              we_q;
  logic [DATA_W-1:0] data_q;

  assign accept = cmd_wr && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = (new_code >= SLOW_CODE) ? ST_MGMT : ST_FAST;
      ST_FAST: state_d = ST_IDLE;
      ST_MGMT: if (mgmt_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      we_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        code_q <= new_code;
        we_q   <= new_we;
        data_q <= stage_q;
      end
    end
  end

  assign fast_req   = (state_q == ST_FAST);
  assign fast_we    = we_q;
  assign fast_addr  = code_q;
  assign fast_wdata = data_q;
  assign mgmt_req   = (state_q == ST_MGMT);
  assign mgmt_we    = we_q;
  assign mgmt_addr  = code_q;
  assign mgmt_wdata = data_q;

  assign done_evt = fast_req || (mgmt_req && mgmt_done);
  assign rd_cap   = done_evt && !we_q;
  assign rd_data  = fast_req ? fast_rdata : mgmt_rdata;
  assign ready    = {!mgmt_req, !fast_req};

  // R3: a fast access lasts exactly one cycle
  a_r3_fast_single: assert property (@(posedge clk) disable iff (!rst_n)
    fast_req |=> !fast_req);
  // R5: the management request holds until done
  a_r5_mgmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req && !mgmt_done |=> mgmt_req);
  // R8: target-side command fields stay fixed during a management access
  a_r8_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req && !mgmt_done |=> $stable(mgmt_wdata) && $stable(mgmt_addr) && $stable(mgmt_we));
  // R6: at most one ready bit is low
  a_r6_one_type: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ready) <= 1);
endmodule

// File: rtl/indirect_access_ctrl.sv
module indirect_access_ctrl
  import iac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 10,
  parameter int SLOW_BASE = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic [7:0]        hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              irq,
  output logic              fast_req,
  output logic              fast_we,
  output logic [CODE_W-1:0] fast_addr,
  output logic [DATA_W-1:0] fast_wdata,
  input  logic [DATA_W-1:0] fast_rdata,
  output logic              mgmt_req,
  output logic              mgmt_we,
  output logic [CODE_W-1:0] mgmt_addr,
  output logic [DATA_W-1:0] mgmt_wdata,
  input  logic [DATA_W-1:0] mgmt_rdata,
  input  logic              mgmt_done
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic              cmd_wr, accept, done_evt, rd_cap;
  logic [DATA_W-1:0] rd_data, stage_q;
  logic [1:0]        ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  iac_host_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) regs_i (
    .clk(clk), .rst_n(rst_sn),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .cmd_wr(cmd_wr), .accept(accept), .done_evt(done_evt),
    .rd_cap(rd_cap), .rd_data(rd_data), .ready(ready),
    .stage_q(stage_q), .irq(irq)
  );

  iac_sequencer #(.DATA_W(DATA_W), .CODE_W(CODE_W), .SLOW_BASE(SLOW_BASE)) seq_i (
    .clk(clk), .rst_n(rst_sn),
    .cmd_wr(cmd_wr), .new_code(hst_wdata[CODE_W-1:0]), .new_we(hst_wdata[WE_BIT]),
    .stage_q(stage_q), .accept(accept), .done_evt(done_evt),
    .rd_cap(rd_cap), .rd_data(rd_data), .ready(ready),
    .fast_req(fast_req), .fast_we(fast_we), .fast_addr(fast_addr),
    .fast_wdata(fast_wdata), .fast_rdata(fast_rdata),
    .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .mgmt_done(mgmt_done)
  );

  // R10: the interrupt never asserts without a recorded completion behind it
  a_r10_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq) |-> $past(done_evt) || $past(hst_wr));
endmodule

// File: tb/indirect_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module indirect_access_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0;
  logic [7:0]  hst_addr = 8'h00;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        irq;
  logic        fast_req, fast_we, mgmt_req, mgmt_we;
  logic [9:0]  fast_addr, mgmt_addr;
  logic [31:0] fast_wdata, mgmt_wdata, fast_rdata;
  logic [31:0] mgmt_rdata = '0;
  logic        mgmt_done = 1'b0;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;
  assign fast_rdata = 32'hA5A5_0000 ^ {22'h0, fast_addr};

  indirect_access_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq),
    .fast_req(fast_req), .fast_we(fast_we), .fast_addr(fast_addr),
    .fast_wdata(fast_wdata), .fast_rdata(fast_rdata),
    .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .mgmt_done(mgmt_done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    hst_addr = a; #0.4; d = hst_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h30, v); chk("R1 ready", v, 32'h3);
    rd(8'h28, v); chk("R1 cmd", v, 32'h0);
    rd(8'h20, v); chk("R1 stage", v, 32'h0);
    rd(8'h34, v); chk("R1 ists", v, 32'h0);
    rd(8'h38, v); chk("R1 ien", v, 32'h0);
    rd(8'h3C, v); chk("R1 gen", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_no_start();
    logic [31:0] v;
    wr(8'h20, 32'h1234_5678);
    chk("R12 no fast_req", {31'h0, fast_req | mgmt_req}, 32'h0);
    wr(8'h38, 32'h1);
    wr(8'h3C, 32'h1);
    chk("R12 no req after enables", {31'h0, fast_req | mgmt_req}, 32'h0);
    rd(8'h30, v); chk("R12 ready", v, 32'h3);
    rd(8'h34, v); chk("R12 no completion", v, 32'h0);
  endtask

  task automatic t_fast_write();
    logic [31:0] v;
    wr(8'h28, 32'hFFFF_FC15);
    chk("R3 fast_req", {31'h0, fast_req}, 32'h1);
    chk("R3 fast_we", {31'h0, fast_we}, 32'h1);
    chk("R3 fast_addr", {22'h0, fast_addr}, 32'h15);
    chk("R3 fast_wdata", fast_wdata, 32'h1234_5678);
    rd(8'h30, v); chk("R6 fast busy ready", v, 32'h2);
    rd(8'h28, v); chk("R2 reserved zero", v, 32'h0000_8015);
    @(negedge clk);
    chk("R3 single cycle", {31'h0, fast_req}, 32'h0);
    rd(8'h30, v); chk("R6 ready back", v, 32'h3);
    rd(8'h34, v); chk("R10 status set", v, 32'h1);
    chk("R10 irq on", {31'h0, irq}, 32'h1);
    wr(8'h34, 32'h1);
    rd(8'h34, v); chk("R11 clear", v, 32'h0);
    chk("R11 irq off", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_fast_read();
    logic [31:0] v;
    wr(8'h28, 32'h0000_0033);
    chk("R3 read dir", {31'h0, fast_we}, 32'h0);
    @(negedge clk);
    rd(8'h20, v); chk("R4 fast capture", v, 32'hA5A5_0033);
  endtask

  task automatic t_irq_gate();
    wr(8'h3C, 32'h0);
    chk("R10 global off", {31'h0, irq}, 32'h0);
    wr(8'h3C, 32'h1);
    chk("R10 both on", {31'h0, irq}, 32'h1);
    wr(8'h38, 32'h0);
    chk("R10 local off", {31'h0, irq}, 32'h0);
    wr(8'h38, 32'h1);
    wr(8'h34, 32'h1);
  endtask

  task automatic t_slow_drop();
    logic [31:0] v;
    wr(8'h20, 32'hCAFE_0001);
    wr(8'h68, 32'h0000_82A5);
    chk("R5 mgmt_req", {31'h0, mgmt_req}, 32'h1);
    chk("R5 mgmt_addr", {22'h0, mgmt_addr}, 32'h2A5);
    chk("R5 mgmt_we", {31'h0, mgmt_we}, 32'h1);
    chk("R9 alias starts", {31'h0, fast_req}, 32'h0);
    rd(8'h30, v); chk("R6 mgmt busy ready", v, 32'h1);
    idle(5);
    chk("R5 held", {31'h0, mgmt_req}, 32'h1);
    wr(8'h20, 32'hDEAD_0000);
    chk("R8 wdata latched", mgmt_wdata, 32'hCAFE_0001);
    wr(8'h28, 32'h0000_0011);
    chk("R7 no fast", {31'h0, fast_req}, 32'h0);
    rd(8'h28, v); chk("R7 cmd unchanged", v, 32'h0000_82A5);
    rd(8'h30, v); chk("R7 ready unchanged", v, 32'h1);
    wr(8'h68, 32'h0000_8123);
    rd(8'h68, v); chk("R9 shared busy", v, 32'h0000_82A5);
    chk("R9 addr unchanged", {22'h0, mgmt_addr}, 32'h2A5);
    @(negedge clk); mgmt_done = 1'b1;
    @(negedge clk); mgmt_done = 1'b0;
    chk("R5 released", {31'h0, mgmt_req}, 32'h0);
    rd(8'h30, v); chk("R6 ready after mgmt", v, 32'h3);
    rd(8'h20, v); chk("R8 write keeps stage", v, 32'hDEAD_0000);
    rd(8'h34, v); chk("R10 mgmt status", v, 32'h1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(8'h34, 32'h1);
    rd(8'h34, v); chk("R11 pre-clear", v, 32'h0);
    wr(8'h28, 32'h0000_03FF);
    chk("R5 top code slow", {31'h0, mgmt_req}, 32'h1);
    idle(3);
    @(negedge clk);
    mgmt_done = 1'b1; mgmt_rdata = 32'h0BAD_F00D;
    hst_wr = 1'b1; hst_addr = 8'h34; hst_wdata = 32'h1;
    @(negedge clk);
    mgmt_done = 1'b0; hst_wr = 1'b0;
    rd(8'h34, v); chk("R11 completion wins", v, 32'h1);
    rd(8'h20, v); chk("R4 mgmt capture", v, 32'h0BAD_F00D);
    wr(8'h34, 32'h1);
    rd(8'h34, v); chk("R11 later clear", v, 32'h0);
    wr(8'h28, 32'h0000_81FF);
    chk("R7 accepted when idle", {31'h0, fast_req}, 32'h1);
    chk("R3 boundary code fast", {22'h0, fast_addr}, 32'h1FF);
    idle(2);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_no_start();
    t_fast_write();
    t_fast_read();
    t_irq_gate();
    t_slow_drop();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule